// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block counts bus clock cycles and raises an interrupt request whenever a programmed number of cycles has elapsed. The vector number and the priority that go with the request are carried in the same control register that starts and stops the timer. A downstream interrupt controller therefore receives a ready-made vector and priority along with the request.

Software reaches the block through single-cycle register accesses: an address, write data and a write strobe, with read data returned combinationally. Periodic use means leaving the timer running. One-shot use means clearing the control register after the first expiry. The safe programming order is to disable the timer, write the period, and then write the enable value.

A build-time compatibility mode restricts the emitted vector to the range 64 to 127. In this mode the priority is folded onto the low vector bits.

The sequencer has two states. `ST_IDLE` holds the count and, on seeing the enable bit set, loads the effective period and takes the transition *arm* to `ST_RUN`. `ST_RUN` decrements the count each cycle and reloads on expiry. It leaves through the transition *halt* back to `ST_IDLE` when the enable bit is clear.

Top module: `pit_timer`

## Requirements
- R1: After reset, `irq_pulse` is low, and reads of the control (0x00), period (0x10) and count (0x14) registers return zero.
- R2: In the control register, bit 26 is the enable, bits 23:20 are the priority and bits 19:12 are the vector. A read returns only these fields in place, with every other bit reading zero.
- R3: The period register at 0x10 reads back what was written. The count register at 0x14 reads the live counter, and writes to it have no effect.
- R4: The register at 0x18 always reads `BUS_PERIOD_NS`, and writes to it are ignored. Any unmapped offset reads zero.
- R5: With period N ≥ 1, suppose enable is written at clock edge W. Then `irq_pulse` is high for exactly the one cycle that follows edge W+1+N.
- R6: While enabled, pulses repeat every N cycles. At each expiry the counter reloads from the period register as it stood at that edge.
- R7: While running, the count register drops by one per cycle, from N down to 1, between reloads.
- R8: Starting from the edge at which a write clears the enable bit, `irq_pulse` stays low and the count register holds its value.
- R9: A period written while the timer is disabled is used from the next enable onward. Counting restarts from that period and does not resume the old count.
- R10: A period of zero behaves as a period of one, so a pulse occurs on every cycle while enabled.
- R11: In normal mode `irq_vector` equals the vector field and `irq_prio` equals the priority field.
- R12: In compatibility mode, `irq_vector` is 0x40 OR (vector[5:0] OR priority<<2), which always lies in 64..127. `irq_prio` is still the priority field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector number presented with the request |
| irq_prio | output | 4 | Priority presented with the request |

## Verification
Several properties are checked on every cycle:
- The counter either holds, steps down by one, or reloads to the effective period.
- Every pulse coincides with a freshly reloaded count.
- A disabling write silences the output from the following edge.
- Reads of the count and bus-period offsets track their sources.
- In compatibility mode, a pulse never carries a vector outside 64..127.

The exact distance from the enable write to the first pulse, the spacing of later pulses, and the restart from a newly written period can only be shown by the bench's timed scenarios. The same holds for the zero-period case and the field decoding of the control register.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pit_state_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_BUSPD  = 8'h18;

    localparam int EN_BIT   = 26;
    localparam int PRIO_LSB = 20;
    localparam int PRIO_W   = 4;
    localparam int VEC_LSB  = 12;
    localparam int VEC_W    = 8;

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                we,
    input  logic [CNT_W-1:0]    count_val,
    output logic [DATA_W-1:0]   rdata,
    output logic                en_q,
    output logic [PRIO_W-1:0]   prio_q,
    output logic [VEC_W-1:0]    vec_q,
    output logic [CNT_W-1:0]    reload_q
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_BUSPD  = ADDR_W'(OFS_BUSPD);

    logic wr_ctrl;
    logic wr_reload;

    assign wr_ctrl   = we && (addr == A_CTRL);
    assign wr_reload = we && (addr == A_RELOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            prio_q   <= '0;
            vec_q    <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= wdata[EN_BIT];
                prio_q <= wdata[PRIO_LSB +: PRIO_W];
                vec_q  <= wdata[VEC_LSB +: VEC_W];
            end
            if (wr_reload) begin
                reload_q <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[EN_BIT]              = en_q;
                rdata[PRIO_LSB +: PRIO_W]  = prio_q;
                rdata[VEC_LSB +: VEC_W]    = vec_q;
            end
            A_RELOAD: rdata = DATA_W'(reload_q);
            A_COUNT:  rdata = DATA_W'(count_val);
            A_BUSPD:  rdata = DATA_W'(BUS_PERIOD_NS);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pit_route.sv
module pit_route
    import pit_pkg::*;
#(
    parameter bit COMPAT_MODE = 1'b0
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic [VEC_W-1:0]  vec,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [PRIO_W-1:0] irq_prio
);

    assign irq_prio = prio;

    generate
        if (COMPAT_MODE) begin : g_folded
            logic [VEC_W-3:0] low_bits;
            assign low_bits   = vec[VEC_W-3:0] | {prio, 2'b00};
            assign irq_vector = {2'b01, low_bits};
        end else begin : g_direct
            assign irq_vector = vec;
        end
    endgenerate

endmodule

// File: rtl/pit_fsm.sv
module pit_fsm
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             fire_q,
    output pit_state_e       state_o
);

    pit_state_e       st_q;
    pit_state_e       st_nx;
    logic [CNT_W-1:0] eff_period;

    assign eff_period = (reload == '0) ? CNT_W'(1) : reload;
    assign state_o    = st_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (en)  st_nx = ST_RUN;
            ST_RUN:  if (!en) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (en) count_q <= eff_period;
                end
                ST_RUN: begin
                    if (en) begin
                        if (count_q == CNT_W'(1)) begin
                            count_q <= eff_period;
                            fire_q  <= 1'b1;
                        end else begin
                            count_q <= count_q - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter bit COMPAT_MODE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector,
    output logic [3:0]        irq_prio
);

    logic              en_w;
    logic [PRIO_W-1:0] prio_w;
    logic [VEC_W-1:0]  vec_w;
    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  count_w;
    logic              fire_w;
    pit_state_e        state_w;

    pit_regs #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .CNT_W         (CNT_W),
        .BUS_PERIOD_NS (BUS_PERIOD_NS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .count_val (count_w),
        .rdata     (reg_rdata),
        .en_q      (en_w),
        .prio_q    (prio_w),
        .vec_q     (vec_w),
        .reload_q  (reload_w)
    );

    pit_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .reload  (reload_w),
        .count_q (count_w),
        .fire_q  (fire_w),
        .state_o (state_w)
    );

    pit_route #(
        .COMPAT_MODE (COMPAT_MODE)
    ) u_route (
        .prio       (prio_w),
        .vec        (vec_w),
        .irq_vector (irq_vector),
        .irq_prio   (irq_prio)
    );

    assign irq_pulse = fire_w & en_w;

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter bit COMPAT_MODE   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_pulse,
    input logic [7:0]        irq_vector,
    input logic [CNT_W-1:0]  count_val,
    input logic [CNT_W-1:0]  reload_val
);

    // R8: a disabling write silences the request from the next edge on
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_CTRL) && !reg_wdata[EN_BIT]) |=> !irq_pulse);

    // R6, R10: each pulse comes with a count freshly reloaded to the effective period
    a_r6_pulse_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (count_val == (($past(reload_val) == '0) ? CNT_W'(1) : $past(reload_val))));

    // R7: the counter only steps down by one or reloads
    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val != $past(count_val)) |->
            ((count_val == $past(count_val) - CNT_W'(1)) ||
             (count_val == (($past(reload_val) == '0) ? CNT_W'(1) : $past(reload_val)))));

    // R3: count offset reads the live counter
    a_r3_count_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_COUNT)) |-> (reg_rdata == DATA_W'(count_val)));

    // R4: bus-period offset is constant
    a_r4_busperiod_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_BUSPD)) |-> (reg_rdata == DATA_W'(BUS_PERIOD_NS)));

    generate
        if (COMPAT_MODE) begin : g_cmp
            // R12: folded vectors stay in 64..127
            a_r12_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
                irq_pulse |-> (irq_vector[7:6] == 2'b01));
        end
    endgenerate

endmodule

bind pit_timer pit_timer_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CNT_W         (CNT_W),
    .BUS_PERIOD_NS (BUS_PERIOD_NS),
    .COMPAT_MODE   (COMPAT_MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .irq_pulse  (irq_pulse),
    .irq_vector (irq_vector),
    .count_val  (count_w),
    .reload_val (reload_w)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;

    localparam int BUSPD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] rdata, rdata_c;
    logic        irq, irq_c;
    logic [7:0]  vec, vec_c;
    logic [3:0]  prio, prio_c;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pit_timer #(.BUS_PERIOD_NS(BUSPD), .COMPAT_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(rdata), .irq_pulse(irq),
        .irq_vector(vec), .irq_prio(prio));

    pit_timer #(.BUS_PERIOD_NS(BUSPD), .COMPAT_MODE(1'b1)) dut_cmp (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(rdata_c), .irq_pulse(irq_c),
        .irq_vector(vec_c), .irq_prio(prio_c));

    // write data, control readback, vector, priority, folded vector
    typedef struct packed {
        logic [31:0] wd;
        logic [31:0] rd;
        logic [7:0]  v;
        logic [3:0]  p;
        logic [7:0]  cv;
    } route_vec_t;

    localparam route_vec_t TBL [5] = '{
        {32'hFBFF_FFFF, 32'h00FF_F000, 8'hFF, 4'hF, 8'h7F},
        {32'h0035_A000, 32'h0035_A000, 8'h5A, 4'h3, 8'h5E},
        {32'h0000_0000, 32'h0000_0000, 8'h00, 4'h0, 8'h40},
        {32'h0090_1ABC, 32'h0090_1000, 8'h01, 4'h9, 8'h65},
        {32'h0A0C_3FFF, 32'h000C_3000, 8'hC3, 4'h0, 8'h43}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        bus_rd(8'h00, r); check("R1 ctrl", r, 32'd0);
        bus_rd(8'h10, r); check("R1 period", r, 32'd0);
        bus_rd(8'h14, r); check("R1 count", r, 32'd0);

        // R2 R11 R12 table walk
        foreach (TBL[i]) begin
            bus_wr(8'h00, TBL[i].wd);
            bus_rd(8'h00, r);
            check("R2 ctrl readback", r, TBL[i].rd);
            check("R11 vector", {24'd0, vec}, {24'd0, TBL[i].v});
            check("R11 prio", {28'd0, prio}, {28'd0, TBL[i].p});
            check("R12 folded vector", {24'd0, vec_c}, {24'd0, TBL[i].cv});
            check("R12 prio", {28'd0, prio_c}, {28'd0, TBL[i].p});
        end

        // R4 bus period, writes ignored, unmapped zero
        bus_rd(8'h18, r); check("R4 busperiod", r, BUSPD);
        bus_wr(8'h18, 32'hDEAD_BEEF);
        bus_rd(8'h18, r); check("R4 busperiod after write", r, BUSPD);
        bus_rd(8'h04, r); check("R4 unmapped", r, 32'd0);

        // R3 period readback, count read-only
        bus_wr(8'h10, 32'd5);
        bus_rd(8'h10, r); check("R3 period readback", r, 32'd5);
        bus_wr(8'h14, 32'h77);
        bus_rd(8'h14, r); check("R3 count write ignored", r, 32'd0);

        // R5 R6 R7 periodic with N=5
        bus_wr(8'h00, 32'h0435_A000);
        reg_addr = 8'h14;
        for (int k = 1; k <= 12; k++) begin
            step();
            check($sformatf("R5 R6 irq k=%0d", k), {31'd0, irq}, {31'd0, (k == 6 || k == 11)});
            if (k == 2) check("R7 count k=2", rdata, 32'd4);
            if (k == 4) check("R7 count k=4", rdata, 32'd2);
            if (k == 6) begin
                check("R11 vector at pulse", {24'd0, vec}, 32'h5A);
                check("R12 folded at pulse", {24'd0, vec_c}, 32'h5E);
                check("R7 reloaded", rdata, 32'd5);
            end
        end

        // R8 one-shot style disable
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h14, r);
        for (int k = 1; k <= 12; k++) begin
            step();
            check("R8 quiet", {31'd0, irq}, 32'd0);
        end
        bus_rd(8'h14, r2);
        check("R8 count frozen", r2, r);

        // R9 new period while disabled restarts
        bus_wr(8'h10, 32'd3);
        bus_wr(8'h00, 32'h0400_0000);
        reg_addr = 8'h14;
        for (int k = 1; k <= 8; k++) begin
            step();
            check($sformatf("R9 irq k=%0d", k), {31'd0, irq}, {31'd0, (k == 4 || k == 7)});
            if (k == 1) check("R9 count restart", rdata, 32'd3);
        end
        bus_wr(8'h00, 32'h0);

        // R10 zero period acts as one
        bus_wr(8'h10, 32'd0);
        bus_wr(8'h00, 32'h0400_0000);
        for (int k = 1; k <= 5; k++) begin
            step();
            check($sformatf("R10 irq k=%0d", k), {31'd0, irq}, {31'd0, (k >= 2)});
        end
        bus_wr(8'h00, 32'h0);
        step();
        check("R8 quiet after zero period", {31'd0, irq}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule